// File: doc/BRIEF.md
# Bridge short-circuit fault locator

This block watches a four-switch full-bridge inverter for a single switch that has failed short. The leg currents of the two low-side switches, S3 and S4, are compared elsewhere against the short-circuit current limit. The limit is twice the rated load current. Each comparison arrives here as an already-synchronized overcurrent flag. The block takes these two flags and the gate commands of S3 and S4 together, at sample instants marked by a strobe from the modulation sequencer. The sequencer places these strobes at quarter-period points.

From each sample the block decides two things. First, whether the pattern shows a short-circuit fault. Second, which of the four switches is the faulty one. The current flags alone cannot tell an S2 fault from an S4 fault, so the gate bits are needed to break that tie. The live result holds until the next strobe. A sticky flag and a latched copy of the first location found keep the diagnosis until the supervising logic clears it. Only one shorted switch at a time is assumed.

Top module: `bridge_sc_locator`

## Requirements
- R1: After reset, fault_now, fault_loc, fault_latched and first_loc are all zero.
- R2: The inputs are captured only on a clock edge where sample_stb is 1. fault_now and fault_loc reflect that capture from the following cycle onward, and hold unchanged until the next strobe, whatever the inputs do in between.
- R3: With the sample written as ABCD = {oc_sw3, oc_sw4, gate_sw3, gate_sw4}, fault_now is 1 for exactly 1010, 0101, 1000, 1001, 0100 and 0110. It is 0 for the other ten patterns.
- R4: fault_loc is one-hot with bit 0 = S1, bit 1 = S2, bit 2 = S3 and bit 3 = S4. Pattern 1010 gives bit 0, and 0101 gives bit 1.
- R5: Patterns 1000 and 1001 give bit 2 (S3), and patterns 0100 and 0110 give bit 3 (S4). So S2 and S4 share their flag pair but are separated by the gate bits.
- R6: fault_loc is all zero whenever fault_now is 0.
- R7: The first evaluation that shows a fault sets fault_latched one cycle after fault_now rises. At the same time, first_loc takes that evaluation's location. Later faults leave first_loc unchanged while the flag is set.
- R8: A clr_sticky pulse clears fault_latched and first_loc on the next edge, and it wins over a simultaneous set. A fault result still held from an earlier strobe does not set the flag again; only a new strobe can.
- R9: Both decoder variants (DECODE_STYLE 0 = full pattern table, 1 = reduced equations) give identical fault_now and fault_loc for all sixteen patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_stb | input | 1 | Sample strobe from the sequencer |
| oc_sw3 | input | 1 | S3 leg current at short-circuit limit (A) |
| oc_sw4 | input | 1 | S4 leg current at short-circuit limit (B) |
| gate_sw3 | input | 1 | Gate command of S3 (C) |
| gate_sw4 | input | 1 | Gate command of S4 (D) |
| clr_sticky | input | 1 | Synchronous clear of the sticky diagnosis |
| fault_now | output | 1 | Fault detected in the last sample |
| fault_loc | output | NUM_SW | One-hot location of the last sample's fault |
| fault_latched | output | 1 | Sticky fault flag |
| first_loc | output | NUM_SW | Location captured with the sticky flag |

## Verification
The bench builds two copies side by side, both with the default four switches: one with DECODE_STYLE 0 and one with DECODE_STYLE 1. It drives the same stimulus into both. This lets every one of the sixteen sample patterns be compared against the expected table and between the two decoder variants at once. With both copies present, a change to either the table or the reduced equations shows up as a mismatch. The directed sequences then stress the sticky path: a second fault of a different kind arriving while the flag is set, a clear that lands in the same cycle as a new fault result, and a clear that is followed by a result still held from an earlier strobe.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
   localparam int unsigned SW_COUNT = 4;
   localparam int unsigned IDX_S1   = 0;
   localparam int unsigned IDX_S2   = 1;
   localparam int unsigned IDX_S3   = 2;
   localparam int unsigned IDX_S4   = 3;

   typedef struct packed {
      logic oc3;   // A
      logic oc4;   // B
      logic g3;    // C
      logic g4;    // D
   } diag_t;
endpackage

// File: rtl/bsc_sampler.sv
module bsc_sampler
   import bsc_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  stb,
   input  diag_t din,
   output diag_t smp,
   output logic  fresh
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp   <= '0;
         fresh <= 1'b0;
      end else begin
         fresh <= stb;
         if (stb) smp <= din;
      end
   end
endmodule

// File: rtl/bsc_decode.sv
module bsc_decode
   import bsc_pkg::*;
#(
   parameter int unsigned NUM_SW       = SW_COUNT,
   parameter int unsigned DECODE_STYLE = 0
)(
   input  diag_t             smp,
   output logic              delta,
   output logic [NUM_SW-1:0] loc
);
   localparam int unsigned PAT_W = $bits(diag_t);

   generate
      if (DECODE_STYLE == 0) begin : g_table
         logic [PAT_W-1:0] pat;
         assign pat = smp;
         always_comb begin
            loc = '0;
            case (pat)
               4'b1010:          loc[IDX_S1] = 1'b1;
               4'b0101:          loc[IDX_S2] = 1'b1;
               4'b1000, 4'b1001: loc[IDX_S3] = 1'b1;
               4'b0100, 4'b0110: loc[IDX_S4] = 1'b1;
               default:          loc = '0;
            endcase
         end
         assign delta = |loc;
      end else begin : g_reduced
         logic only3, only4;
         assign only3 = smp.oc3 & ~smp.oc4;
         assign only4 = smp.oc4 & ~smp.oc3;
         assign delta = (smp.oc3 ^ smp.oc4) & ~(smp.g3 & smp.g4);
         always_comb begin
            loc         = '0;
            loc[IDX_S1] = only3 &  smp.g3 & ~smp.g4;
            loc[IDX_S2] = only4 & ~smp.g3 &  smp.g4;
            loc[IDX_S3] = only3 & ~smp.g3;
            loc[IDX_S4] = only4 & ~smp.g4;
         end
      end
   endgenerate
endmodule

// File: rtl/bsc_sticky.sv
module bsc_sticky #(
   parameter int unsigned NUM_SW = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              fresh,
   input  logic              delta,
   input  logic [NUM_SW-1:0] loc,
   output logic              latched,
   output logic [NUM_SW-1:0] first
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latched <= 1'b0;
         first   <= '0;
      end else if (clr) begin
         latched <= 1'b0;
         first   <= '0;
      end else if (fresh && delta && !latched) begin
         latched <= 1'b1;
         first   <= loc;
      end
   end
endmodule

// File: rtl/bridge_sc_locator.sv
module bridge_sc_locator
   import bsc_pkg::*;
#(
   parameter int unsigned NUM_SW       = SW_COUNT,
   parameter int unsigned DECODE_STYLE = 0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample_stb,
   input  logic              oc_sw3,
   input  logic              oc_sw4,
   input  logic              gate_sw3,
   input  logic              gate_sw4,
   input  logic              clr_sticky,
   output logic              fault_now,
   output logic [NUM_SW-1:0] fault_loc,
   output logic              fault_latched,
   output logic [NUM_SW-1:0] first_loc
);
   generate
      if (NUM_SW != SW_COUNT) begin : g_bad_width
         $error("bridge_sc_locator: NUM_SW must be 4");
      end
      if (DECODE_STYLE > 1) begin : g_bad_style
         $error("bridge_sc_locator: DECODE_STYLE must be 0 or 1");
      end
   endgenerate

   diag_t din, smp;
   logic  fresh;

   assign din = '{oc3: oc_sw3, oc4: oc_sw4, g3: gate_sw3, g4: gate_sw4};

   bsc_sampler u_smp (
      .clk(clk), .rst_n(rst_n), .stb(sample_stb),
      .din(din), .smp(smp), .fresh(fresh)
   );

   bsc_decode #(.NUM_SW(NUM_SW), .DECODE_STYLE(DECODE_STYLE)) u_dec (
      .smp(smp), .delta(fault_now), .loc(fault_loc)
   );

   bsc_sticky #(.NUM_SW(NUM_SW)) u_stk (
      .clk(clk), .rst_n(rst_n), .clr(clr_sticky), .fresh(fresh),
      .delta(fault_now), .loc(fault_loc),
      .latched(fault_latched), .first(first_loc)
   );
endmodule

// File: rtl/bsc_checker.sv
module bsc_checker #(
   parameter int unsigned W = 4
)(
   input logic         clk,
   input logic         rst_n,
   input logic         sample_stb,
   input logic         clr_sticky,
   input logic         fault_now,
   input logic [W-1:0] fault_loc,
   input logic         fault_latched,
   input logic [W-1:0] first_loc
);
   a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_stb |=> ($stable(fault_loc) && $stable(fault_now)));

   a_r4_loc_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fault_loc));

   a_r6_loc_vs_delta: assert property (@(posedge clk) disable iff (!rst_n)
      fault_now == (fault_loc != '0));

   a_r7_keep_first: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_latched && !clr_sticky) |=> (fault_latched && $stable(first_loc)));

   a_r7_first_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      fault_latched == (first_loc != '0));

   a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      clr_sticky |=> !fault_latched);
endmodule

bind bridge_sc_locator bsc_checker #(.W(NUM_SW)) u_chk (
   .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .clr_sticky(clr_sticky),
   .fault_now(fault_now), .fault_loc(fault_loc),
   .fault_latched(fault_latched), .first_loc(first_loc)
);

// File: tb/sim_bridge_sc_locator.sv
module sim_bridge_sc_locator;
   localparam int CLK_NS = 10;
   // entry: {ABCD[8:5], delta[4], loc[3:0]}; loc bit0=S1 .. bit3=S4
   localparam logic [8:0] VEC [16] = '{
      9'b0000_0_0000, 9'b0001_0_0000, 9'b0010_0_0000, 9'b0011_0_0000,
      9'b0100_1_1000, 9'b0101_1_0010, 9'b0110_1_1000, 9'b0111_0_0000,
      9'b1000_1_0100, 9'b1001_1_0100, 9'b1010_1_0001, 9'b1011_0_0000,
      9'b1100_0_0000, 9'b1101_0_0000, 9'b1110_0_0000, 9'b1111_0_0000
   };

   logic clk = 1'b0, rst_n = 1'b0, stb = 1'b0, clr = 1'b0;
   logic [3:0] abcd = '0;
   logic       dn0, dn1, lt0, lt1;
   logic [3:0] lc0, lc1, fl0, fl1;
   int nchk = 0, nfail = 0;

   always #(CLK_NS/2) clk = ~clk;

   bridge_sc_locator #(.DECODE_STYLE(0)) u0 (
      .clk(clk), .rst_n(rst_n), .sample_stb(stb),
      .oc_sw3(abcd[3]), .oc_sw4(abcd[2]), .gate_sw3(abcd[1]), .gate_sw4(abcd[0]),
      .clr_sticky(clr), .fault_now(dn0), .fault_loc(lc0),
      .fault_latched(lt0), .first_loc(fl0)
   );
   bridge_sc_locator #(.DECODE_STYLE(1)) u1 (
      .clk(clk), .rst_n(rst_n), .sample_stb(stb),
      .oc_sw3(abcd[3]), .oc_sw4(abcd[2]), .gate_sw3(abcd[1]), .gate_sw4(abcd[0]),
      .clr_sticky(clr), .fault_now(dn1), .fault_loc(lc1),
      .fault_latched(lt1), .first_loc(fl1)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic apply(input logic [3:0] p);
      @(negedge clk); abcd = p; stb = 1'b1;
      @(negedge clk); stb = 1'b0;
   endtask

   task automatic pulse_clr;
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
   endtask

   initial begin
      #(CLK_NS * 50000);
      nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 u0", {2'b0, dn0, lt0, lc0}, 8'h00);
      check("R1 first", {fl0, fl1}, 8'h00);
      rst_n = 1'b1;

      // R3 R4 R5 R6 R9: full pattern walk
      for (int i = 0; i < 16; i++) begin
         apply(VEC[i][8:5]);
         check($sformatf("R3 delta pat=%b", VEC[i][8:5]), {7'b0, dn0}, {7'b0, VEC[i][4]});
         check($sformatf("R4 R5 R6 loc pat=%b", VEC[i][8:5]), {4'b0, lc0}, {4'b0, VEC[i][3:0]});
         check($sformatf("R9 variants pat=%b", VEC[i][8:5]), {3'b0, dn1, lc1}, {3'b0, VEC[i][4], VEC[i][3:0]});
      end

      // R8 clear, then sticky from a fresh fault
      pulse_clr();
      check("R8 cleared", {3'b0, lt0, fl0}, 8'h00);
      apply(4'b0101);                       // S2
      check("R7 not yet", {7'b0, lt0}, 8'h00);
      @(negedge clk);
      check("R7 set", {3'b0, lt0, fl0}, {3'b0, 1'b1, 4'b0010});
      apply(4'b1000);                       // S3 while latched
      @(negedge clk);
      check("R7 first kept", {3'b0, lt0, fl0}, {3'b0, 1'b1, 4'b0010});
      check("R5 S3 live", {4'b0, lc0}, 8'b0000_0100);

      // R8 clear with held fault result: no re-set
      pulse_clr();
      repeat (2) @(negedge clk);
      check("R8 no reset from held", {2'b0, dn0, lt0, fl0}, {2'b0, 1'b1, 1'b0, 4'b0000});

      // R8 clear simultaneous with new result
      @(negedge clk); abcd = 4'b1010; stb = 1'b1;
      @(negedge clk); stb = 1'b0; clr = 1'b1;
      @(negedge clk); clr = 1'b0;
      @(negedge clk);
      check("R8 clear wins", {3'b0, lt0, fl0}, 8'h00);
      check("R4 S1 live", {3'b0, dn0, lc0}, {3'b0, 1'b1, 4'b0001});

      // R2 inputs ignored between strobes
      abcd = 4'b0101;
      repeat (4) @(negedge clk);
      check("R2 hold", {3'b0, dn0, lc0}, {3'b0, 1'b1, 4'b0001});
      abcd = 4'b1111;
      repeat (2) @(negedge clk);
      check("R2 hold no-fault input", {3'b0, dn1, lc1}, {3'b0, 1'b1, 4'b0001});
      apply(4'b1111);
      check("R2 R6 update on strobe", {3'b0, dn0, lc0}, 8'h00);

      // R1 reset mid-run
      apply(4'b0110);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 reset again", {lt0, dn0, 2'b0, lc0 | fl0}, 8'h00);

      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule